// File: doc/BRIEF.md
# Flash Block-Erase Command Sequencer

This block models the command interface and write state machine that a NOR-style flash device uses to erase a block. Bus write cycles carry a command byte and a block address. Erase needs two writes: a setup write, then a confirm write. When the confirm is accepted, a timed erase runs for a parameterised number of cycles. Each refusal cause sets its own pair of error bits in an 8-bit status register. An active-low status pin reflects busy or ready.

A running erase can be suspended. After a short latency it parks at a safe point. While parked, only a restricted command set is honoured. One of the allowed commands starts a nested program operation on another block. Resume continues the erase from the remaining cycle count. Array reads are enabled through `arr_ok_o`, which stays low for the block whose erase is parked. Inputs model the program-enable voltage, a reset-pin high-voltage override and per-block lock bits.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, status_o reads 0x80, busy_n_o is 1 and arr_ok_o is 1 (array read mode).
- R2: Writing 0x20 and then 0xD0 with the voltage valid and the block unlocked starts an erase. From the confirm edge, status bit 7 and busy_n_o read 0 for exactly ERASE_CYC cycles, and status then returns to 0x80.
- R3: After 0x20, a second write that is not 0xD0 is an invalid sequence. It sets status bits 5 and 4 (status 0xB0) and no erase runs.
- R4: A confirm while vpen_ok_i is 0 sets status bits 5 and 3 (0xA8) and no erase runs.
- R5: A confirm on a block whose lock_i bit is set, while rp_hv_i is 0, sets status bits 5 and 1 (0xA2) and no erase runs. With rp_hv_i at 1, the same block erases normally.
- R6: Writing 0xB0 during an erase suspends it after SUSP_LAT cycles. Status then reads 0xC0 and busy_n_o is 1. The remaining count is frozen, so after a 0xD0 resume the erase finishes once the cycles still owed have elapsed.
- R7: If the erase count expires in the same cycle as the suspend latency, or earlier, the erase completes. Status reads 0x80 with bit 6 clear.
- R8: While suspended, commands outside the set {0xFF, 0x40, 0x98, 0x70, 0x50, 0xB8, 0xD0} are ignored. For example, 0x20 leaves status at 0xC0.
- R9: While suspended and in array mode (0xFF), arr_ok_o is 0 when rd_blk_i equals the suspended block and 1 for any other block.
- R10: A program (0x40, then a data write) takes PROG_CYC cycles from the data edge. During it, status bit 7 and busy_n_o read 0. In suspend, bit 6 stays 1, a resume written during the program is ignored, and status returns to 0xC0 afterwards. A data write with vpen_ok_i at 0 sets bits 4 and 3.
- R11: Error bits 5, 4, 3 and 1 stay set across other commands until 0x50 is written, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Bus write strobe, one cycle per write |
| cmd_i | input | 8 | Command or data byte |
| blk_i | input | BLK_W | Block address of the write |
| vpen_ok_i | input | 1 | Program-enable voltage is valid |
| rp_hv_i | input | 1 | Reset pin at high voltage, overrides lock bits |
| lock_i | input | NUM_BLK | Per-block lock bits |
| rd_blk_i | input | BLK_W | Block targeted by array reads |
| status_o | output | 8 | Status register |
| busy_n_o | output | 1 | 0 while an operation runs, 1 when ready |
| arr_ok_o | output | 1 | Array read data may be returned for rd_blk_i |

## Verification
The collision that matters is the suspend latency expiring in the same cycle as the final erase count. The bench sweeps the suspend write over every cycle offset within the erase, so the latency ends before, exactly at, and after the count runs out. For each offset it computes whether the erase parks or finishes. When the erase parks, it also computes how many cycles remain after resume, and it compares the status byte and busy pin at those exact cycles.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ESET, ST_PSET, ST_ERASE, ST_SPEND,
    ST_SUSP, ST_PSET_S, ST_PROG, ST_PROG_S
  } state_e;

  typedef enum logic [3:0] {
    CM_ESET, CM_CONF, CM_SUSP, CM_RDSR, CM_CLR,
    CM_RDARR, CM_PRG, CM_QRY, CM_CFG, CM_NONE
  } cmd_e;

  typedef enum logic [1:0] {RM_ARR, RM_STAT, RM_QRY} rmode_e;

  localparam logic [7:0] OP_ESET  = 8'h20;
  localparam logic [7:0] OP_CONF  = 8'hD0;
  localparam logic [7:0] OP_SUSP  = 8'hB0;
  localparam logic [7:0] OP_RDSR  = 8'h70;
  localparam logic [7:0] OP_CLR   = 8'h50;
  localparam logic [7:0] OP_RDARR = 8'hFF;
  localparam logic [7:0] OP_PRG   = 8'h40;
  localparam logic [7:0] OP_QRY   = 8'h98;
  localparam logic [7:0] OP_CFG   = 8'hB8;

  localparam int SB_RDY  = 7;
  localparam int SB_ESUS = 6;
  localparam int SB_EERR = 5;
  localparam int SB_PERR = 4;
  localparam int SB_VPEN = 3;
  localparam int SB_LOCK = 1;
  localparam logic [7:0] ERR_MASK = 8'h3A;
endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
  import flash_seq_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_e       cmd_o
);
  always_comb begin
    case (op_i)
      OP_ESET:  cmd_o = CM_ESET;
      OP_CONF:  cmd_o = CM_CONF;
      OP_SUSP:  cmd_o = CM_SUSP;
      OP_RDSR:  cmd_o = CM_RDSR;
      OP_CLR:   cmd_o = CM_CLR;
      OP_RDARR: cmd_o = CM_RDARR;
      OP_PRG:   cmd_o = CM_PRG;
      OP_QRY:   cmd_o = CM_QRY;
      OP_CFG:   cmd_o = CM_CFG;
      default:  cmd_o = CM_NONE;
    endcase
  end
endmodule

// File: rtl/fes_timer.sv
module fes_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = run_i && (cnt_q == W'(1));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fes_status.sv
module fes_status
  import flash_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [7:0] set_i,
  output logic [7:0] err_o
);
  logic [7:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= '0;
    else if (clr_i) err_q <= set_i & ERR_MASK;
    else            err_q <= (err_q | set_i) & ERR_MASK;
  end

  assign err_o = err_q;

  // R11
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == 8'h00) |=> (err_o == 8'h00));

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((err_o & $past(err_o)) == $past(err_o)));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_seq_pkg::*;
#(
  parameter int NUM_BLK   = 4,
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 4,
  parameter int SUSP_LAT  = 3,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [7:0]         cmd_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic               vpen_ok_i,
  input  logic               rp_hv_i,
  input  logic [NUM_BLK-1:0] lock_i,
  input  logic [BLK_W-1:0]   rd_blk_i,
  output logic [7:0]         status_o,
  output logic               busy_n_o,
  output logic               arr_ok_o
);
  localparam int EW = $clog2(ERASE_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam int LW = $clog2(SUSP_LAT + 1);

  state_e            st_q, st_d;
  rmode_e            mode_q, mode_d;
  cmd_e              cmd;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [7:0]        set_m, err;
  logic              clr;
  logic              e_load, p_load, l_load;
  logic              e_last, p_last, l_last;
  logic              e_run, p_run, l_run;
  logic              rdy, esus, lock_cur, lock_sav;

  fes_cmd_decode u_dec (.op_i(cmd_i), .cmd_o(cmd));

  assign e_run = (st_q == ST_ERASE) || (st_q == ST_SPEND);
  assign p_run = (st_q == ST_PROG) || (st_q == ST_PROG_S);
  assign l_run = (st_q == ST_SPEND);

  fes_timer #(.W(EW)) u_ers (
    .clk_i, .rst_ni, .load_i(e_load), .val_i(EW'(ERASE_CYC)),
    .run_i(e_run), .last_o(e_last));
  fes_timer #(.W(PW)) u_prg (
    .clk_i, .rst_ni, .load_i(p_load), .val_i(PW'(PROG_CYC)),
    .run_i(p_run), .last_o(p_last));
  fes_timer #(.W(LW)) u_lat (
    .clk_i, .rst_ni, .load_i(l_load), .val_i(LW'(SUSP_LAT)),
    .run_i(l_run), .last_o(l_last));

  fes_status u_sts (.clk_i, .rst_ni, .clr_i(clr), .set_i(set_m), .err_o(err));

  assign lock_cur = lock_i[blk_i] && !rp_hv_i;
  assign lock_sav = lock_i[blk_q] && !rp_hv_i;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    blk_d  = blk_q;
    set_m  = '0;
    clr    = 1'b0;
    e_load = 1'b0;
    p_load = 1'b0;
    l_load = 1'b0;
    case (st_q)
      ST_IDLE: if (we_i) begin
        case (cmd)
          CM_ESET:  begin st_d = ST_ESET; mode_d = RM_STAT; blk_d = blk_i; end
          CM_PRG:   begin st_d = ST_PSET; mode_d = RM_STAT; end
          CM_RDSR:  mode_d = RM_STAT;
          CM_CLR:   clr = 1'b1;
          CM_RDARR: mode_d = RM_ARR;
          CM_QRY:   mode_d = RM_QRY;
          default:  ;
        endcase
      end
      ST_ESET: if (we_i) begin
        mode_d = RM_STAT;
        st_d   = ST_IDLE;
        if (cmd != CM_CONF) begin
          set_m[SB_EERR] = 1'b1;
          set_m[SB_PERR] = 1'b1;
        end else begin
          if (!vpen_ok_i) begin set_m[SB_EERR] = 1'b1; set_m[SB_VPEN] = 1'b1; end
          if (lock_sav)   begin set_m[SB_EERR] = 1'b1; set_m[SB_LOCK] = 1'b1; end
          if (vpen_ok_i && !lock_sav) begin e_load = 1'b1; st_d = ST_ERASE; end
        end
      end
      ST_PSET, ST_PSET_S: if (we_i) begin
        st_d = (st_q == ST_PSET) ? ST_IDLE : ST_SUSP;
        if (!vpen_ok_i) begin set_m[SB_PERR] = 1'b1; set_m[SB_VPEN] = 1'b1; end
        if (lock_cur)   begin set_m[SB_PERR] = 1'b1; set_m[SB_LOCK] = 1'b1; end
        if (vpen_ok_i && !lock_cur) begin
          p_load = 1'b1;
          st_d   = (st_q == ST_PSET) ? ST_PROG : ST_PROG_S;
        end
      end
      ST_ERASE: begin
        if (e_last) st_d = ST_IDLE;
        else if (we_i && cmd == CM_SUSP) begin
          l_load = 1'b1;
          st_d   = ST_SPEND;
          mode_d = RM_STAT;
        end
      end
      ST_SPEND: begin
        if (e_last)      st_d = ST_IDLE;   // completion wins over parking
        else if (l_last) st_d = ST_SUSP;
      end
      ST_SUSP: if (we_i) begin
        case (cmd)
          CM_PRG:   begin st_d = ST_PSET_S; mode_d = RM_STAT; end
          CM_CONF:  begin st_d = ST_ERASE;  mode_d = RM_STAT; end
          CM_RDSR:  mode_d = RM_STAT;
          CM_CLR:   clr = 1'b1;
          CM_RDARR: mode_d = RM_ARR;
          CM_QRY:   mode_d = RM_QRY;
          default:  ;   // configure accepted without effect; rest ignored
        endcase
      end
      ST_PROG:   if (p_last) st_d = ST_IDLE;
      ST_PROG_S: if (p_last) st_d = ST_SUSP;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= RM_ARR;
      blk_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      blk_q  <= blk_d;
    end
  end

  assign rdy  = !(e_run || p_run);
  assign esus = (st_q == ST_SUSP) || (st_q == ST_PSET_S) || (st_q == ST_PROG_S);

  always_comb begin
    status_o          = err;
    status_o[SB_RDY]  = rdy;
    status_o[SB_ESUS] = esus;
  end

  assign busy_n_o = rdy;
  assign arr_ok_o = (mode_q == RM_ARR) && rdy && !(esus && rd_blk_i == blk_q);

  // R4
  vpen_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ESET && we_i && cmd == CM_CONF && !vpen_ok_i)
    |=> (st_q == ST_IDLE && status_o[SB_VPEN] && status_o[SB_EERR]));

  // R5
  lock_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ESET && we_i && cmd == CM_CONF && lock_i[blk_q] && !rp_hv_i)
    |=> (st_q == ST_IDLE && status_o[SB_LOCK] && status_o[SB_EERR]));

  // R7
  done_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SPEND && e_last) |=> (st_q == ST_IDLE && !status_o[SB_ESUS]));

  // R6
  park_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SPEND && l_last && !e_last)
    |=> (busy_n_o && status_o[SB_RDY] && status_o[SB_ESUS]));

  // R10
  nested_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG_S) |-> (!busy_n_o && status_o[SB_ESUS]));
endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
  localparam int NB = 4;
  localparam int EC = 12;
  localparam int PC = 4;
  localparam int SL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [1:0] blk = 2'd0;
  logic       vpen = 1'b1;
  logic       rphv = 1'b0;
  logic [3:0] lock = 4'b0000;
  logic [1:0] rd_blk = 2'd0;
  logic [7:0] status;
  logic       busy_n, arr_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_erase_seq #(.NUM_BLK(NB), .ERASE_CYC(EC), .PROG_CYC(PC), .SUSP_LAT(SL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .cmd_i(cmd), .blk_i(blk),
    .vpen_ok_i(vpen), .rp_hv_i(rphv), .lock_i(lock), .rd_blk_i(rd_blk),
    .status_o(status), .busy_n_o(busy_n), .arr_ok_o(arr_ok));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] c, input logic [1:0] b);
    @(negedge clk);
    we = 1'b1; cmd = c; blk = b;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wait_ready(output int k);
    k = 0;
    while (!status[7] && k < 4 * EC) begin tick(); k++; end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status in reset", status, 8'h80);
    @(negedge clk) rst_n = 1'b1;
    tick();
    chk("R1 status", status, 8'h80);
    chk("R1 busy_n", busy_n, 1);
    chk("R1 arr_ok", arr_ok, 1);

    // R2 plain erase
    wr(8'h20, 2'd1);
    chk("R2 after setup", status, 8'h80);
    wr(8'hD0, 2'd1);
    chk("R2 busy status", status, 8'h00);
    chk("R2 busy pin", busy_n, 0);
    wait_ready(k);
    chk("R2 erase length", k, EC);
    chk("R2 done status", status, 8'h80);

    // R3 invalid sequence, R11 persistence
    wr(8'h20, 2'd0);
    wr(8'hFF, 2'd0);
    chk("R3 bad sequence", status, 8'hB0);
    chk("R3 not busy", busy_n, 1);
    repeat (EC) tick();
    chk("R3 no erase ran", status, 8'hB0);
    wr(8'hFF, 2'd0);
    chk("R11 kept after read array", status, 8'hB0);
    chk("R11 array mode", arr_ok, 1);
    wr(8'h70, 2'd0);
    chk("R11 kept after read status", status, 8'hB0);
    wr(8'h50, 2'd0);
    chk("R11 cleared", status, 8'h80);

    // R4 voltage
    vpen = 1'b0;
    wr(8'h20, 2'd1);
    wr(8'hD0, 2'd1);
    chk("R4 vpen refuse", status, 8'hA8);
    tick();
    chk("R4 no erase", busy_n, 1);
    vpen = 1'b1;
    wr(8'h50, 2'd0);

    // R5 lock and override
    lock = 4'b0100;
    wr(8'h20, 2'd2);
    wr(8'hD0, 2'd2);
    chk("R5 lock refuse", status, 8'hA2);
    wr(8'h50, 2'd0);
    rphv = 1'b1;
    wr(8'h20, 2'd2);
    wr(8'hD0, 2'd2);
    chk("R5 override erases", status, 8'h00);
    wait_ready(k);
    chk("R5 override length", k, EC);
    rphv = 1'b0;
    lock = 4'b0000;

    // R6 / R7 sweep of suspend offset
    for (int s = 1; s < EC; s++) begin
      wr(8'h20, 2'd1);
      wr(8'hD0, 2'd1);
      repeat (s - 1) tick();
      wr(8'hB0, 2'd1);
      repeat (SL - 1) tick();
      if (s + SL - 1 < EC) chk("R6 busy during latency", status, 8'h00);
      tick();
      if (s + SL < EC) begin
        chk("R6 parked status", status, 8'hC0);
        chk("R6 parked pin", busy_n, 1);
        repeat (2) tick();
        chk("R6 frozen while parked", status, 8'hC0);
        wr(8'hD0, 2'd1);
        chk("R6 resumed busy", status, 8'h00);
        wait_ready(k);
        chk("R6 remaining cycles", k, EC - s - SL);
      end else begin
        chk("R7 completion wins", status, 8'h80);
      end
    end

    // R8 / R9 / R10 inside suspend
    wr(8'h20, 2'd1);
    wr(8'hD0, 2'd1);
    wr(8'hB0, 2'd1);
    repeat (SL) tick();
    chk("R8 parked", status, 8'hC0);
    wr(8'h20, 2'd3);
    chk("R8 setup ignored", status, 8'hC0);
    wr(8'hD0, 2'd3);
    chk("R8 next D0 is resume", status, 8'h00);
    wr(8'hB0, 2'd1);
    repeat (SL) tick();
    wr(8'hFF, 2'd0);
    rd_blk = 2'd1; #1;
    chk("R9 suspended block blocked", arr_ok, 0);
    rd_blk = 2'd0; #1;
    chk("R9 other block readable", arr_ok, 1);
    rd_blk = 2'd3; #1;
    chk("R9 other block readable", arr_ok, 1);
    wr(8'h40, 2'd0);
    chk("R10 setup in suspend", status, 8'hC0);
    wr(8'hAB, 2'd2);
    chk("R10 nested busy", status, 8'h40);
    chk("R10 nested pin", busy_n, 0);
    wr(8'hD0, 2'd1);
    chk("R10 resume ignored", status, 8'h40);
    wait_ready(k);
    chk("R10 program length", k, PC - 1);
    chk("R10 back to parked", status, 8'hC0);
    wr(8'hD0, 2'd1);
    wait_ready(k);
    chk("R6 remaining after nest", k, EC - 2 - 2 * SL);
    chk("R6 final", status, 8'h80);

    // R10 program refusal
    vpen = 1'b0;
    wr(8'h40, 2'd0);
    wr(8'h12, 2'd0);
    chk("R10 program vpen refuse", status, 8'h98);
    vpen = 1'b1;
    wr(8'h40, 2'd0);
    wr(8'h12, 2'd0);
    chk("R10 sticky after program", status, 8'h18);
    wait_ready(k);
    chk("R10 idle program length", k, PC);
    wr(8'h50, 2'd0);
    chk("R11 final clear", status, 8'h80);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule